// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

This block turns a serial bit stream into a parallel word. Bits enter a chain of shift stages, one bit per rising edge of a dedicated shift clock. A second, independent storage clock copies the whole chain at once into a storage register. The storage register drives the parallel pins through tri-state buffers.

Because the serial output is taken from the last shift stage, several instances can be chained by wiring one serial output to the next serial input. With common clocks, N instances accept 8×N bits over 8×N shift pulses, and a single storage pulse then updates every parallel output together.

The active-low master reset is asynchronous and acts on the shift stages alone. The storage register keeps its value through a reset, so the outputs hold steady while a new word is being prepared.

Top module: `latched_sipo`

## Requirements
- R1: On every rising edge of `shift_clk` with `mr_n` high, stage 0 takes `ser_in` and each stage k (k from 0 to WIDTH-2) passes its value to stage k+1.
- R2: `ser_out` always shows the last shift stage, so after a shift edge it carries the value stage WIDTH-2 held just before that edge; it is always driven (never high impedance).
- R3: On every rising edge of `store_clk` the storage register takes a copy of all shift stages in parallel.
- R4: Driving `mr_n` low clears every shift stage at once, without waiting for a clock, so `ser_out` goes low; the storage register and `par_q` keep their values; shift edges during reset leave the stages at zero.
- R5: A `store_clk` edge while `mr_n` is low loads all zeros into the storage register.
- R6: With `oe_n` low, `par_q` drives the storage register; with `oe_n` high all bits of `par_q` are high impedance (a weak pull-up on the bus then reads 0xFF).
- R7: `oe_n` changes nothing in the shift stages or the storage register; shifting and storing done while the outputs are off appear once they are turned on.
- R8: When `shift_clk` and `store_clk` rise together, the storage register captures the stage contents from before that edge, so with tied clocks the stored word lags by one pulse.
- R9: `par_q[i]` is storage bit i, taken from shift stage i; stage 0 is the one that receives serial data. After WIDTH shifts, the first bit sent sits on `par_q[WIDTH-1]`.
- R10: Two instances chained `ser_out` to `ser_in`, with common clocks, accept 2×WIDTH bits over 2×WIDTH shift pulses. One store pulse then puts the later bits on the first instance and the earlier bits on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_clk | input | 1 | Shift clock; stages advance on its rising edge |
| store_clk | input | 1 | Storage clock; copies the stages on its rising edge |
| mr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| ser_in | input | 1 | Serial data into stage 0 |
| par_q | output | WIDTH | Tri-state parallel outputs from the storage register |
| ser_out | output | 1 | Serial cascade output from the last stage |

## Verification
The checker tests the following at every clock edge:
- stage 0 takes the serial input that was sampled one shift edge earlier;
- the cascade output repeats the next-to-last stage from one shift edge earlier;
- each storage edge captures exactly the stage contents sampled at that edge;
- the stages are zero while reset is held;
- enabled outputs match the storage register.

Some behaviour can only be shown by the bench's scenarios. These are:
- reset landing between a shift burst and its store, with the old word kept on the pins;
- the high-impedance level seen through the pull-up;
- a word built entirely while the outputs are off;
- the two-instance chain.

A queue model in the bench follows all of these pulse by pulse. It also flags any setup, hold or reset-recovery violation in the stimulus.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the latched serial-to-parallel register.
// Assumes: consumers take their default width from here.
package lsr_pkg;
    localparam int unsigned LSR_WIDTH = 8;
    localparam int unsigned LSR_MIN_WIDTH = 2;
endpackage

// File: rtl/lsr_shift_chain.sv
`timescale 1ns/1ps
// Module: lsr_shift_chain
// Serial-in shift chain. Stage 0 takes ser_in, and every stage feeds the
// next one on a rising shift_clk edge.
// Assumes: mr_n is an asynchronous active-low clear that affects only
// these stages, and W >= 2.
module lsr_shift_chain #(
    parameter int unsigned W = lsr_pkg::LSR_WIDTH
) (
    input  logic         shift_clk,
    input  logic         mr_n,
    input  logic         ser_in,
    output logic [W-1:0] stages
);
    localparam int unsigned TOP = W - 1;

    // Purpose: advance the chain by one place, or clear it on reset.
    always_ff @(posedge shift_clk or negedge mr_n) begin
        if (!mr_n) begin
            stages <= '0;
        end else begin
            stages <= {stages[TOP-1:0], ser_in};
        end
    end
endmodule

// File: rtl/lsr_hold_reg.sv
`timescale 1ns/1ps
// Module: lsr_hold_reg
// Storage register. It copies all the shift stages on a rising store_clk edge.
// Assumes: there is deliberately no reset here, because the contents must
// survive a master reset. Reset reaches this register only through the
// zeros it captures from the cleared stages.
module lsr_hold_reg #(
    parameter int unsigned W = lsr_pkg::LSR_WIDTH
) (
    input  logic         store_clk,
    input  logic [W-1:0] stages,
    output logic [W-1:0] hold
);
    // Purpose: take the parallel copy of the stages.
    always_ff @(posedge store_clk) begin
        hold <= stages;
    end
endmodule

// File: rtl/lsr_out_drv.sv
`timescale 1ns/1ps
// Module: lsr_out_drv
// Per-bit tri-state drivers for the parallel outputs.
// Assumes: oe_n is active low. While disabled, every bit floats.
module lsr_out_drv #(
    parameter int unsigned W = lsr_pkg::LSR_WIDTH
) (
    input  logic         oe_n,
    input  logic [W-1:0] hold,
    output logic [W-1:0] pins
);
    for (genvar b = 0; b < W; b++) begin : g_drv
        // Purpose: drive one pin from its storage bit, or release it.
        assign pins[b] = oe_n ? 1'bz : hold[b];
    end
endmodule

// File: rtl/latched_sipo.sv
`timescale 1ns/1ps
// Module: latched_sipo
// Serial-in shift chain, followed by a separately clocked storage register
// with tri-state parallel outputs. The cascade output is the last stage.
// Assumes: shift_clk and store_clk are independent clocks (they may be
// tied). mr_n clears the shift stages only.
module latched_sipo #(
    parameter int unsigned WIDTH = lsr_pkg::LSR_WIDTH
) (
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             mr_n,
    input  logic             oe_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] par_q,
    output logic             ser_out
);
    localparam int unsigned LAST = WIDTH - 1;

    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] hold_q;

    lsr_shift_chain #(.W(WIDTH)) u_chain (
        .shift_clk (shift_clk),
        .mr_n      (mr_n),
        .ser_in    (ser_in),
        .stages    (shift_q)
    );

    lsr_hold_reg #(.W(WIDTH)) u_hold (
        .store_clk (store_clk),
        .stages    (shift_q),
        .hold      (hold_q)
    );

    lsr_out_drv #(.W(WIDTH)) u_drv (
        .oe_n (oe_n),
        .hold (hold_q),
        .pins (par_q)
    );

    // Purpose: bring the last stage out for cascading.
    assign ser_out = shift_q[LAST];
endmodule

// File: rtl/lsr_chk.sv
`timescale 1ns/1ps
// Module: lsr_chk
// Timing properties of latched_sipo, attached through a bind.
// Assumes: it is connected to the top's internal stage and storage vectors.
module lsr_chk #(
    parameter int unsigned W = lsr_pkg::LSR_WIDTH
) (
    input logic         shift_clk,
    input logic         store_clk,
    input logic         mr_n,
    input logic         oe_n,
    input logic         ser_in,
    input logic         ser_out,
    input logic [W-1:0] stages,
    input logic [W-1:0] hold,
    input logic [W-1:0] par_q
);
    logic         clean;
    logic         st_seen;
    logic [W-1:0] st_snap;

    // Purpose: record whether the previous shift edge ran with reset off.
    always_ff @(posedge shift_clk or negedge mr_n) begin
        if (!mr_n) clean <= 1'b0;
        else       clean <= 1'b1;
    end

    // Purpose: remember the stage contents seen at the previous storage edge.
    always_ff @(posedge store_clk) begin
        st_seen <= 1'b1;
        st_snap <= stages;
    end

    // R1: stage 0 holds the serial input sampled at the previous shift edge
    a_r1_stage0_entry: assert property (@(posedge shift_clk) disable iff (!mr_n)
        clean |-> stages[0] == $past(ser_in));

    // R2: the cascade output repeats the next-to-last stage of the previous edge
    a_r2_cascade_lag: assert property (@(posedge shift_clk) disable iff (!mr_n)
        clean |-> ser_out == $past(stages[W-2]));

    // R3, R5, R8: storage equals the stages sampled at the last storage edge
    a_r3_store_copy: assert property (@(posedge store_clk) disable iff (!mr_n)
        st_seen |-> hold == st_snap);

    // R4: while reset is held, the stages and the cascade output stay zero
    a_r4_reset_clears: assert property (@(posedge store_clk)
        !mr_n |-> (stages == '0 && ser_out == 1'b0));

    // R6: enabled outputs show the storage register
    a_r6_drive: assert property (@(posedge store_clk) disable iff (!mr_n)
        !oe_n |-> par_q == hold);
endmodule

bind latched_sipo lsr_chk #(.W(WIDTH)) u_lsr_chk (
    .shift_clk (shift_clk),
    .store_clk (store_clk),
    .mr_n      (mr_n),
    .oe_n      (oe_n),
    .ser_in    (ser_in),
    .ser_out   (ser_out),
    .stages    (shift_q),
    .hold      (hold_q),
    .par_q     (par_q)
);

// File: tb/test_latched_sipo.sv
`timescale 1ns/1ps
// Bench for latched_sipo. A queue model follows every pulse and is compared
// with the design on each falling edge of the 125 MHz base clock.
module test_latched_sipo;
    localparam int W = 8;
    localparam realtime T_SU  = 1.5;
    localparam realtime T_HLD = 1.0;
    localparam realtime T_REC = 2.5;

    logic clk = 1'b0, shift_clk = 1'b0, store_clk = 1'b0;
    logic mr_n = 1'b1, oe_n = 1'b1, ser_in = 1'b0;
    wire [W-1:0] par_q, c0_q, c1_q;
    wire ser_out, c0_so, c1_so;

    always #4 clk = ~clk;

    latched_sipo #(.WIDTH(W)) i_latched_sipo (.shift_clk(shift_clk), .store_clk(store_clk),
        .mr_n(mr_n), .oe_n(oe_n), .ser_in(ser_in), .par_q(par_q), .ser_out(ser_out));
    latched_sipo #(.WIDTH(W)) i_chain0 (.shift_clk(shift_clk), .store_clk(store_clk),
        .mr_n(mr_n), .oe_n(oe_n), .ser_in(ser_in), .par_q(c0_q), .ser_out(c0_so));
    latched_sipo #(.WIDTH(W)) i_chain1 (.shift_clk(shift_clk), .store_clk(store_clk),
        .mr_n(mr_n), .oe_n(oe_n), .ser_in(c0_so), .par_q(c1_q), .ser_out(c1_so));

    for (genvar i = 0; i < W; i++) begin : g_pu
        pullup (par_q[i]);
    end

    bit mq[$];
    bit cq[$];
    logic [W-1:0] m_hold, c0_hold, c1_hold;
    bit hold_ok = 1'b0;
    int checks = 0, errors = 0, viol = 0, cyc = 0;
    string cur_req = "R4";
    realtime t_din = -100.0, t_sh = -100.0, t_rel = -100.0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] qv(input int base, input bit is_chain);
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = is_chain ? cq[base + i] : mq[base + i];
        return v;
    endfunction

    task automatic clear_model();
        mq.delete(); cq.delete();
        for (int i = 0; i < W; i++) mq.push_back(1'b0);
        for (int i = 0; i < 2 * W; i++) cq.push_back(1'b0);
    endtask

    // One clock slot: data changes, then clock edges 2 ns later, released 4 ns after that
    task automatic pulse(input bit sh, input bit st, input bit d);
        logic [W-1:0] pre, p0, p1;
        @(posedge clk);
        ser_in = d;
        #2;
        pre = qv(0, 1'b0); p0 = qv(0, 1'b1); p1 = qv(W, 1'b1);
        shift_clk = sh; store_clk = st;
        if (st) begin m_hold = pre; c0_hold = p0; c1_hold = p1; hold_ok = 1'b1; end
        if (sh && mr_n) begin
            mq.push_front(d); void'(mq.pop_back());
            cq.push_front(d); void'(cq.pop_back());
        end
        #4;
        shift_clk = 1'b0; store_clk = 1'b0;
    endtask

    task automatic set_reset(input bit v);
        @(posedge clk); #1;
        mr_n = v;
        if (v) t_rel = $realtime; else clear_model();
    endtask

    task automatic set_oe(input bit v);
        @(posedge clk); #1;
        oe_n = v;
    endtask

    // Model comparison on every base clock
    always @(negedge clk) begin
        if (mq.size() == W) begin
            chk(cur_req, ser_out, mq[W-1]);
            chk(cur_req, c1_so, cq[2*W-1]);
            if (oe_n) chk(cur_req, par_q, {W{1'b1}});
            else if (hold_ok) begin
                chk(cur_req, par_q, m_hold);
                chk(cur_req, c0_q, c0_hold);
                chk(cur_req, c1_q, c1_hold);
            end
        end
    end

    // Stimulus timing monitors: setup, hold, reset recovery
    always @(ser_in) begin
        if ($realtime - t_sh < T_HLD) viol++;
        t_din = $realtime;
    end
    always @(posedge shift_clk) begin
        if ($realtime - t_din < T_SU) viol++;
        if ($realtime - t_rel < T_REC) viol++;
        t_sh = $realtime;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++; errors++;
            $display("FAIL %s watchdog actual %0d expected below 50000", cur_req, cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] expv;
        logic [15:0] wide;
        #3 mr_n = 1'b0;
        clear_model();
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R4", ser_out, 1'b0);

        // R5: store under reset gives zeros
        cur_req = "R5";
        pulse(1'b0, 1'b1, 1'b1);
        set_oe(1'b0);
        @(negedge clk); chk("R5", par_q, 8'h00);
        set_reset(1'b1);

        // R1, R9: shift 0xB2 MSB first, so stage j ends up holding bit j
        cur_req = "R1";
        expv = 8'hB2;
        for (int i = W - 1; i >= 0; i--) pulse(1'b1, 1'b0, expv[i]);
        @(negedge clk); chk("R2", ser_out, 1'b1);
        cur_req = "R3";
        pulse(1'b0, 1'b1, 1'b0);
        @(negedge clk); chk("R9", par_q, 8'hB2);
        cur_req = "R2";
        pulse(1'b1, 1'b0, 1'b0);
        @(negedge clk); chk("R2", ser_out, 1'b0);

        // R8: tied clocks, storage lags by one pulse
        cur_req = "R8";
        for (int i = 0; i < 10; i++) pulse(1'b1, 1'b1, (i % 3) == 0);
        expv = qv(0, 1'b0);
        pulse(1'b1, 1'b1, 1'b1);
        @(negedge clk); chk("R8", par_q, expv);

        // R4: reset between shifting and storing keeps the old word
        cur_req = "R4";
        for (int i = W - 1; i >= 0; i--) pulse(1'b1, 1'b0, (8'hC5 >> i) & 1);
        pulse(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, 1'b1);
        set_reset(1'b0);
        @(negedge clk); chk("R4", ser_out, 1'b0); chk("R4", par_q, 8'hC5);
        pulse(1'b1, 1'b0, 1'b1);
        @(negedge clk); chk("R4", ser_out, 1'b0); chk("R4", par_q, 8'hC5);
        cur_req = "R5";
        pulse(1'b0, 1'b1, 1'b1);
        @(negedge clk); chk("R5", par_q, 8'h00);
        set_reset(1'b1);

        // R6, R7: outputs off while a new word is built
        cur_req = "R6";
        for (int i = W - 1; i >= 0; i--) pulse(1'b1, 1'b0, (8'h3C >> i) & 1);
        pulse(1'b0, 1'b1, 1'b0);
        set_oe(1'b1);
        @(negedge clk); chk("R6", par_q, 8'hFF);
        cur_req = "R7";
        for (int i = W - 1; i >= 0; i--) pulse(1'b1, 1'b0, (8'h5A >> i) & 1);
        pulse(1'b0, 1'b1, 1'b0);
        @(negedge clk); chk("R6", par_q, 8'hFF);
        set_oe(1'b0);
        @(negedge clk); chk("R7", par_q, 8'h5A);

        // R10: two chained instances, 16 shifts then one store
        cur_req = "R10";
        wide = 16'hA53C;
        for (int i = 2 * W - 1; i >= 0; i--) pulse(1'b1, 1'b0, wide[i]);
        pulse(1'b0, 1'b1, 1'b0);
        @(negedge clk); chk("R10", c0_q, 8'h3C); chk("R10", c1_q, 8'hA5);

        chk("TIMING", viol, 0);
        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule